// File: doc/BRIEF.md
# Reset and Sleep Wake Controller

This block gathers every reason the core can be reset: power-on, an active-low external reset pin, and a watchdog expiry. When any of them fires, the core is held in reset for a programmable start-up interval. While that interval runs, the block also asserts load-default enables for the program counter, the status register, the port direction registers, the control register and the watchdog. The block accepts sleep and watchdog-clear command strobes from the core. A sleep command stops the oscillator. The device leaves sleep only through a reset, either from the pin or from a watchdog expiry.

Two status flags, a time-out flag and a power-down flag, record how the core arrived at its current state. Software reads them after a reset to tell the causes apart:

| Flags (time-out, power-down) | Meaning |
|---|---|
| 1, 1 | Cold start |
| 0, x | Watchdog expiry |
| 1, 0 | Pin wake from sleep |

A pin reset leaves both flags untouched. All interfaces are plain level or strobe signals, with no handshake. The pin input is synchronised inside the block. The other inputs are expected to be synchronous to `clk`.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst`, `flag_t` and `flag_p` are all 1. After `por_n` rises, `core_rst` stays 1 for exactly `HOLD_TICKS` rising clock edges and then drops to 0.
- R2: A low level on `rst_pin_n` passes through a two-stage synchroniser. `core_rst` is 1 after the third rising edge following the pin's fall. The hold restarts on every edge while the synchronised pin is low. `core_rst` falls `HOLD_TICKS` + 2 edges after the pin returns high.
- R3: A `wdt_timeout` pulse while `wdt_en` is 1, in any state, sets `core_rst` to 1 and `flag_t` to 0 on the next edge, and leaves `flag_p` unchanged.
- R4: A `wdt_timeout` pulse while `wdt_en` is 0 has no effect on `core_rst`, `osc_stop` or the flags.
- R5: A `cmd_sleep` strobe while running, with no reset cause present, sets `osc_stop` to 1, `flag_t` to 1 and `flag_p` to 0 on the next edge.
- R6: A `cmd_wdt_clear` strobe while running, with no sleep strobe and no reset cause present, sets both `flag_t` and `flag_p` to 1 on the next edge.
- R7: A reset caused by the pin leaves `flag_t` and `flag_p` unchanged.
- R8: In sleep, both command strobes are ignored. Only the pin or an enabled watchdog expiry ends sleep. `osc_stop` returns to 0 in the same cycle that `core_rst` rises.
- R9: While `core_rst` is 1, both command strobes are ignored.
- R10: `dflt_pc`, `dflt_status`, `dflt_portdir` and `dflt_ctrl` equal `core_rst`. `wdt_clr` is 1 during the hold, and for the one cycle after an accepted sleep or watchdog-clear strobe.
- R11: When `cmd_sleep` and `cmd_wdt_clear` arrive in the same cycle, the sleep strobe wins: `osc_stop` becomes 1 and `flag_p` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enabled, which qualifies `wdt_timeout` |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| cmd_sleep | input | 1 | Sleep command strobe from the core |
| cmd_wdt_clear | input | 1 | Watchdog-clear command strobe from the core |
| core_rst | output | 1 | Core reset, high during the start-up hold |
| osc_stop | output | 1 | Oscillator stop request, high while asleep |
| flag_t | output | 1 | Time-out flag |
| flag_p | output | 1 | Power-down flag |
| dflt_pc | output | 1 | Load the program counter reset value |
| dflt_status | output | 1 | Load the status register reset value |
| dflt_portdir | output | 1 | Set all port pins to input |
| dflt_ctrl | output | 1 | Load the control and watchdog-control defaults |
| wdt_clr | output | 1 | Clear the watchdog and its prescaler |

## Verification
Command strobes and enabled watchdog expiries show their effect on the outputs one edge later. A pin fall shows its effect three edges later, because the two synchroniser stages add two edges. A hold ends `HOLD_TICKS` edges after the last cycle in which a reset cause was seen. Inputs change on falling clock edges. Outputs are compared on the following falling edge against a behavioural model that is stepped on each rising edge. Directed checks count edges explicitly from each stimulus, so each result is sampled in the exact cycle it is due.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [1:0] {
    RWC_HOLD  = 2'd0,
    RWC_RUN   = 2'd1,
    RWC_SLEEP = 2'd2
  } rwc_state_e;
endpackage

// File: rtl/rwc_pin_sync.sv
module rwc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_low
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], pin_n};
  end

  assign pin_low = ~sync_q[STAGES-1];
endmodule

// File: rtl/rwc_hold_timer.sv
module rwc_hold_timer #(
  parameter int HOLD_TICKS = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic restart,
  input  logic active,
  output logic done
);
  localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  cnt_q <= '0;
    else if (restart || !active) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && !restart && (cnt_q == LAST);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= LAST);
  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rwc_flags.sv
module rwc_flags (
  input  logic clk,
  input  logic por_n,
  input  logic wdt_hit,
  input  logic sleep_ok,
  input  logic clr_ok,
  output logic flag_t,
  output logic flag_p
);
  logic t_q, p_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end else if (wdt_hit) begin
      t_q <= 1'b0;
    end else if (sleep_ok) begin
      t_q <= 1'b1;
      p_q <= 1'b0;
    end else if (clr_ok) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end
  end

  assign flag_t = t_q;
  assign flag_p = p_q;

  p_quiet_flags_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_hit && !sleep_ok && !clr_ok) |=> ($stable(t_q) && $stable(p_q)));
  p_wdt_clears_t_r3: assert property (@(posedge clk) disable iff (!por_n)
    wdt_hit |=> (!t_q && $stable(p_q)));
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl #(
  parameter int HOLD_TICKS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic wdt_en,
  input  logic wdt_timeout,
  input  logic cmd_sleep,
  input  logic cmd_wdt_clear,
  output logic core_rst,
  output logic osc_stop,
  output logic flag_t,
  output logic flag_p,
  output logic dflt_pc,
  output logic dflt_status,
  output logic dflt_portdir,
  output logic dflt_ctrl,
  output logic wdt_clr
);
  import rwc_pkg::*;

  rwc_state_e state_q, state_d;
  logic pin_low, wdt_hit, trig, in_run, hold_done;
  logic sleep_ok, clr_ok, wclr_q;

  rwc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .pin_low(pin_low)
  );

  assign wdt_hit  = wdt_timeout && wdt_en;
  assign trig     = pin_low || wdt_hit;
  assign in_run   = (state_q == RWC_RUN);
  assign sleep_ok = in_run && cmd_sleep && !trig;
  assign clr_ok   = in_run && cmd_wdt_clear && !cmd_sleep && !trig;

  rwc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk(clk), .por_n(por_n), .restart(trig),
    .active(state_q == RWC_HOLD), .done(hold_done)
  );

  rwc_flags u_flags (
    .clk(clk), .por_n(por_n), .wdt_hit(wdt_hit),
    .sleep_ok(sleep_ok), .clr_ok(clr_ok),
    .flag_t(flag_t), .flag_p(flag_p)
  );

  always_comb begin
    state_d = state_q;
    if (trig) state_d = RWC_HOLD;
    else begin
      unique case (state_q)
        RWC_HOLD:  if (hold_done) state_d = RWC_RUN;
        RWC_RUN:   if (sleep_ok)  state_d = RWC_SLEEP;
        RWC_SLEEP: state_d = RWC_SLEEP;
        default:   state_d = RWC_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= RWC_HOLD;
      wclr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wclr_q  <= sleep_ok || clr_ok;
    end
  end

  assign core_rst     = (state_q == RWC_HOLD);
  assign osc_stop     = (state_q == RWC_SLEEP);
  assign dflt_pc      = core_rst;
  assign dflt_status  = core_rst;
  assign dflt_portdir = core_rst;
  assign dflt_ctrl    = core_rst;
  assign wdt_clr      = core_rst || wclr_q;

  p_wdt_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
    wdt_hit |=> core_rst);
  p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && cmd_sleep && !trig) |=> (osc_stop && flag_t && !flag_p));
  p_clear_flags_r6: assert property (@(posedge clk) disable iff (!por_n)
    (in_run && cmd_wdt_clear && !cmd_sleep && !trig) |=> (flag_t && flag_p));
  p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!por_n)
    (osc_stop && !trig) |=> osc_stop);
  p_excl_r8: assert property (@(posedge clk) disable iff (!por_n)
    !(osc_stop && core_rst));
  p_hold_cmds_r9: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst && !wdt_hit) |=> ($stable(flag_t) && $stable(flag_p)));
endmodule

// File: tb/tb_rst_wake_ctrl.sv
module tb_rst_wake_ctrl;
  localparam int HT = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1, wdt_en = 1'b1, wdt_timeout = 1'b0;
  logic cmd_sleep = 1'b0, cmd_wdt_clear = 1'b0;
  logic core_rst, osc_stop, flag_t, flag_p;
  logic dflt_pc, dflt_status, dflt_portdir, dflt_ctrl, wdt_clr;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // reference model state: 0 hold, 1 run, 2 sleep
  int m_state = 0, m_cnt = 0, m_t = 1, m_p = 1, m_s1 = 1, m_s2 = 1, m_wc = 0;

  always #2 clk = ~clk;

  rst_wake_ctrl #(.HOLD_TICKS(HT)) dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdt_en(wdt_en),
    .wdt_timeout(wdt_timeout), .cmd_sleep(cmd_sleep), .cmd_wdt_clear(cmd_wdt_clear),
    .core_rst(core_rst), .osc_stop(osc_stop), .flag_t(flag_t), .flag_p(flag_p),
    .dflt_pc(dflt_pc), .dflt_status(dflt_status), .dflt_portdir(dflt_portdir),
    .dflt_ctrl(dflt_ctrl), .wdt_clr(wdt_clr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int trig, whit, sok, cok;
    cyc++;
    if (!por_n) begin
      m_state = 0; m_cnt = 0; m_t = 1; m_p = 1; m_s1 = 1; m_s2 = 1; m_wc = 0;
    end else begin
      whit = (wdt_timeout && wdt_en) ? 1 : 0;
      trig = (m_s2 == 0 || whit) ? 1 : 0;
      sok  = (m_state == 1 && cmd_sleep && !trig) ? 1 : 0;
      cok  = (m_state == 1 && cmd_wdt_clear && !cmd_sleep && !trig) ? 1 : 0;
      if (whit) m_t = 0;
      else if (sok) begin m_t = 1; m_p = 0; end
      else if (cok) begin m_t = 1; m_p = 1; end
      m_wc = sok | cok;
      if (trig) begin m_state = 0; m_cnt = 0; end
      else if (m_state == 0) begin
        if (m_cnt == HT - 1) begin m_state = 1; m_cnt = 0; end
        else m_cnt++;
      end else if (sok) m_state = 2;
      m_s2 = m_s1; m_s1 = rst_pin_n;
    end
  end

  always @(negedge clk) begin
    if (por_n && !done) begin
      chk("R1 core_rst vs model", core_rst, m_state == 0);
      chk("R8 osc_stop vs model", osc_stop, m_state == 2);
      chk("R3 flag_t vs model", flag_t, m_t);
      chk("R5 flag_p vs model", flag_p, m_p);
      chk("R10 dflt enables", {dflt_pc, dflt_status, dflt_portdir, dflt_ctrl},
          (m_state == 0) ? 15 : 0);
      chk("R10 wdt_clr vs model", wdt_clr, (m_state == 0 || m_wc) ? 1 : 0);
    end
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep(logic s, logic c);
    cmd_sleep = s; cmd_wdt_clear = c;
    tick();
    cmd_sleep = 0; cmd_wdt_clear = 0;
  endtask

  task automatic pulse_wdt();
    wdt_timeout = 1; tick(); wdt_timeout = 0;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    tick(3);
    chk("R1 reset core_rst", core_rst, 1);
    chk("R1 reset flag_t", flag_t, 1);
    chk("R1 reset flag_p", flag_p, 1);
    por_n = 1;
    tick(HT - 1);
    chk("R1 still held", core_rst, 1);
    tick();
    chk("R1 released", core_rst, 0);

    pulse_sleep(1, 0);
    chk("R5 osc_stop", osc_stop, 1);
    chk("R5 flag_t", flag_t, 1);
    chk("R5 flag_p", flag_p, 0);
    chk("R10 wdt_clr after sleep", wdt_clr, 1);
    pulse_sleep(0, 1);
    chk("R8 clear ignored in sleep", flag_p, 0);
    chk("R8 still asleep", osc_stop, 1);
    pulse_wdt();
    chk("R8 wake reset", core_rst, 1);
    chk("R8 osc restart", osc_stop, 0);
    chk("R3 flag_t cleared", flag_t, 0);
    chk("R3 flag_p kept", flag_p, 0);
    tick(HT);
    chk("R3 hold over", core_rst, 0);

    pulse_sleep(0, 1);
    chk("R6 flag_t", flag_t, 1);
    chk("R6 flag_p", flag_p, 1);

    wdt_en = 0;
    pulse_wdt();
    chk("R4 no reset", core_rst, 0);
    chk("R4 flag_t kept", flag_t, 1);
    wdt_en = 1;

    pulse_sleep(1, 0);
    rst_pin_n = 0;
    tick(2);
    chk("R2 not yet", core_rst, 0);
    tick();
    chk("R2 reset via pin", core_rst, 1);
    chk("R7 flag_t kept", flag_t, 1);
    chk("R7 flag_p kept", flag_p, 0);
    tick(4);
    rst_pin_n = 1;
    tick(5);
    pulse_sleep(0, 1);
    chk("R9 clear ignored in hold", flag_p, 0);
    tick(3);
    chk("R2 still held", core_rst, 1);
    tick();
    chk("R2 released", core_rst, 0);

    pulse_sleep(1, 1);
    chk("R11 sleep wins osc", osc_stop, 1);
    chk("R11 sleep wins flag_p", flag_p, 0);
    pulse_wdt();
    tick(HT);

    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_sleep     = (lfsr[3:0] == 4'd1);
      cmd_wdt_clear = (lfsr[3:0] == 4'd2) || (lfsr[7:4] == 4'd5);
      wdt_timeout   = (lfsr[7:0] == 8'd7) || (lfsr[8:1] == 8'd99);
      wdt_en        = lfsr[9] | lfsr[11];
      if (lfsr[11:4] == 8'd3) rst_pin_n = 0;
      else if (lfsr[2:0] == 3'd6) rst_pin_n = 1;
      tick();
    end
    cmd_sleep = 0; cmd_wdt_clear = 0; wdt_timeout = 0; rst_pin_n = 1;
    tick(HT + 4);
    finish_run();
  end
endmodule